// File: doc/BRIEF.md
# Execute-Stage Operand Bypass and Load Hazard Detector

This block sits beside the execute stage of a five-stage in-order integer pipeline. It decides where each of the two ALU operands comes from. The first choice is the register-file value latched when the instruction left decode. The second is the ALU result sitting in the register between execute and memory. The third is the value being written back in the final stage. It drives the selected operand words to the ALU, and it also exposes the 2-bit select codes for each operand.

The block also works out which register the instruction in execute will write. That is either its second source field or its third register field, chosen by a destination-select control bit. The destination number then travels down the pipeline with the instruction.

A loaded value only exists at the end of the memory stage. An instruction in decode that reads the target of a load currently in execute therefore cannot be served by bypassing. For that case the block raises a stall request. The surrounding pipeline holds fetch and decode for one cycle and injects a bubble into execute. The whole block is combinational. Its outputs answer the current stage contents in the same cycle.

Top module: `fwd_unit`

## Requirements
- R1: Select encoding per operand is 2'b00 = register-file value, 2'b10 = value from the execute/memory register, 2'b01 = writeback value; the code 2'b11 never appears.
- R2: An operand selects the execute/memory value (2'b10) when `memWrEn` is 1, `memDest` is non-zero and `memDest` equals that operand's source number (`exRs` for operand A, `exRt` for operand B).
- R3: An operand selects the writeback value (2'b01) when `wbWrEn` is 1, `wbDest` is non-zero, `wbDest` equals its source number, and the condition of R2 does not hold for it.
- R4: When both the memory stage and the writeback stage match a source, the memory stage wins (select 2'b10).
- R5: A stage whose write enable is 0, or whose destination is register 0, never causes bypassing; such an operand selects 2'b00.
- R6: `operandA` and `operandB` equal exactly the word named by their select: `exRfA`/`exRfB`, `memAluResult` or `wbValue`.
- R7: `exDest` equals `exRd` when `exRegDst` is 1 and `exRt` when it is 0.
- R8: `loadUseStall` is 1 exactly when `exMemRead` is 1, `exDest` is non-zero and `exDest` equals `idRs` or `idRt`; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs | input | REG_W | First source register number of the instruction in decode |
| idRt | input | REG_W | Second source register number of the instruction in decode |
| exRs | input | REG_W | First source register number of the instruction in execute |
| exRt | input | REG_W | Second source register number of the instruction in execute |
| exRd | input | REG_W | Third register field of the instruction in execute |
| exRegDst | input | 1 | 1: destination is `exRd`; 0: destination is `exRt` |
| exMemRead | input | 1 | Instruction in execute is a load |
| exRfA | input | DATA_W | Register-file value of operand A latched at decode |
| exRfB | input | DATA_W | Register-file value of operand B latched at decode |
| memDest | input | REG_W | Destination number held in the execute/memory register |
| memWrEn | input | 1 | Register-write enable of the memory-stage instruction |
| memAluResult | input | DATA_W | ALU result held in the execute/memory register |
| wbDest | input | REG_W | Destination number of the writeback-stage instruction |
| wbWrEn | input | 1 | Register-write enable of the writeback-stage instruction |
| wbValue | input | DATA_W | Value being written back |
| fwdSelA | output | 2 | Source select of operand A (encoding in R1) |
| fwdSelB | output | 2 | Source select of operand B (encoding in R1) |
| operandA | output | DATA_W | Operand A delivered to the ALU |
| operandB | output | DATA_W | Operand B delivered to the ALU |
| exDest | output | REG_W | Destination register number of the instruction in execute |
| loadUseStall | output | 1 | Request to hold decode one cycle and insert a bubble |

## Verification
The bench sweeps every combination of source numbers, stage destinations and write enables over registers 0 to 7, so the collision cases are all reached: both later stages naming the same register, a match on register 0, and a match whose write enable is off. A design with reversed priority would hand the ALU a stale writeback value when both stages match. A design that ignored the write enable or register 0 would bypass a value that never reaches the register file. A second sweep covers the load check against both decode source fields and both destination choices. That sweep catches a stall raised for a non-load instruction, for a load into register 0, or from the wrong destination field.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_OPS = 2;

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  // Strobes from the comparator control to the operand datapath.
  typedef struct packed {
    logic [NUM_OPS-1:0] memHit;
    logic [NUM_OPS-1:0] wbHit;
    logic               loadUse;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPS-1:0][REG_W-1:0] exSrc,
  input  logic [REG_W-1:0]              idRs,
  input  logic [REG_W-1:0]              idRt,
  input  logic [REG_W-1:0]              exDest,
  input  logic                          exMemRead,
  input  logic [REG_W-1:0]              memDest,
  input  logic                          memWrEn,
  input  logic [REG_W-1:0]              wbDest,
  input  logic                          wbWrEn,
  output fwdStrobes_t                   strobes
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic memLive;
  logic wbLive;
  logic loadLive;

  // A stage is a bypass candidate only if it really writes a real register.
  assign memLive  = memWrEn && (memDest != ZERO_REG);
  assign wbLive   = wbWrEn && (wbDest != ZERO_REG);
  assign loadLive = exMemRead && (exDest != ZERO_REG);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_cmp
    assign strobes.memHit[op] = memLive && (memDest == exSrc[op]);
    assign strobes.wbHit[op]  = wbLive && (wbDest == exSrc[op]);
  end

  assign strobes.loadUse = loadLive && ((exDest == idRs) || (exDest == idRt));
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t                    strobes,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] exRf,
  input  logic [DATA_W-1:0]              memAluResult,
  input  logic [DATA_W-1:0]              wbValue,
  input  logic [REG_W-1:0]               exRt,
  input  logic [REG_W-1:0]               exRd,
  input  logic                           exRegDst,
  output logic [NUM_OPS-1:0][1:0]        opSel,
  output logic [NUM_OPS-1:0][DATA_W-1:0] operand,
  output logic [REG_W-1:0]               exDest
);
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    // Newer result (memory stage) takes precedence over writeback.
    always_comb begin
      if (strobes.memHit[op]) begin
        opSel[op] = SEL_MEM;
      end else if (strobes.wbHit[op]) begin
        opSel[op] = SEL_WB;
      end else begin
        opSel[op] = SEL_RF;
      end
    end

    always_comb begin
      unique case (opSel[op])
        SEL_MEM: operand[op] = memAluResult;
        SEL_WB:  operand[op] = wbValue;
        default: operand[op] = exRf[op];
      endcase
    end
  end

  assign exDest = exRegDst ? exRd : exRt;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  idRs,
  input  logic [REG_W-1:0]  idRt,
  input  logic [REG_W-1:0]  exRs,
  input  logic [REG_W-1:0]  exRt,
  input  logic [REG_W-1:0]  exRd,
  input  logic              exRegDst,
  input  logic              exMemRead,
  input  logic [DATA_W-1:0] exRfA,
  input  logic [DATA_W-1:0] exRfB,
  input  logic [REG_W-1:0]  memDest,
  input  logic              memWrEn,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic [REG_W-1:0]  wbDest,
  input  logic              wbWrEn,
  input  logic [DATA_W-1:0] wbValue,
  output logic [1:0]        fwdSelA,
  output logic [1:0]        fwdSelB,
  output logic [DATA_W-1:0] operandA,
  output logic [DATA_W-1:0] operandB,
  output logic [REG_W-1:0]  exDest,
  output logic              loadUseStall
);
  fwdStrobes_t                    strobes;
  logic [NUM_OPS-1:0][REG_W-1:0]  exSrc;
  logic [NUM_OPS-1:0][DATA_W-1:0] exRf;
  logic [NUM_OPS-1:0][1:0]        opSel;
  logic [NUM_OPS-1:0][DATA_W-1:0] operand;

  assign exSrc = {exRt, exRs};
  assign exRf  = {exRfB, exRfA};

  fwd_ctrl #(.REG_W(REG_W)) u_ctrl (
    .exSrc     (exSrc),
    .idRs      (idRs),
    .idRt      (idRt),
    .exDest    (exDest),
    .exMemRead (exMemRead),
    .memDest   (memDest),
    .memWrEn   (memWrEn),
    .wbDest    (wbDest),
    .wbWrEn    (wbWrEn),
    .strobes   (strobes)
  );

  fwd_datapath #(.REG_W(REG_W), .DATA_W(DATA_W)) u_dp (
    .strobes      (strobes),
    .exRf         (exRf),
    .memAluResult (memAluResult),
    .wbValue      (wbValue),
    .exRt         (exRt),
    .exRd         (exRd),
    .exRegDst     (exRegDst),
    .opSel        (opSel),
    .operand      (operand),
    .exDest       (exDest)
  );

  assign fwdSelA      = opSel[0];
  assign fwdSelB      = opSel[1];
  assign operandA     = operand[0];
  assign operandB     = operand[1];
  assign loadUseStall = strobes.loadUse;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  idRs,
  input logic [REG_W-1:0]  idRt,
  input logic [REG_W-1:0]  exRs,
  input logic [REG_W-1:0]  exRt,
  input logic [REG_W-1:0]  exRd,
  input logic              exMemRead,
  input logic [DATA_W-1:0] exRfA,
  input logic [DATA_W-1:0] exRfB,
  input logic [REG_W-1:0]  memDest,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memAluResult,
  input logic [REG_W-1:0]  wbDest,
  input logic              wbWrEn,
  input logic [DATA_W-1:0] wbValue,
  input logic [1:0]        fwdSelA,
  input logic [1:0]        fwdSelB,
  input logic [DATA_W-1:0] operandA,
  input logic [DATA_W-1:0] operandB,
  input logic [REG_W-1:0]  exDest,
  input logic              loadUseStall
);
  always_comb begin
    AST_SEL_A_LEGAL: assert (fwdSelA != 2'b11) else $error("selA illegal"); // R1
    AST_SEL_B_LEGAL: assert (fwdSelB != 2'b11) else $error("selB illegal"); // R1
    AST_MEM_WINS_A: assert (!(memWrEn && memDest != '0 && memDest == exRs) || fwdSelA == 2'b10) else $error("mem bypass A"); // R2
    AST_WB_ONLY_B: assert (!(wbWrEn && wbDest != '0 && wbDest == exRt && !(memWrEn && memDest == exRt)) || fwdSelB == 2'b01) else $error("wb bypass B"); // R3
    AST_ZERO_SRC_A: assert (exRs != '0 || fwdSelA == 2'b00) else $error("r0 bypass A"); // R5
    AST_OPA_RF: assert (fwdSelA != 2'b00 || operandA == exRfA) else $error("opA rf"); // R6
    AST_OPB_RF: assert (fwdSelB != 2'b00 || operandB == exRfB) else $error("opB rf"); // R6
    AST_OPA_MEM: assert (fwdSelA != 2'b10 || operandA == memAluResult) else $error("opA mem"); // R6
    AST_OPB_WB: assert (fwdSelB != 2'b01 || operandB == wbValue) else $error("opB wb"); // R6
    AST_DEST_FIELD: assert (exDest == exRd || exDest == exRt) else $error("dest field"); // R7
    AST_STALL_LOAD: assert (!loadUseStall || exMemRead) else $error("stall no load"); // R8
    AST_STALL_MATCH: assert (!loadUseStall || (exDest != '0 && (exDest == idRs || exDest == idRt))) else $error("stall no match"); // R8
  end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0]  idRs, idRt, exRs, exRt, exRd, memDest, wbDest;
  logic              exRegDst, exMemRead, memWrEn, wbWrEn;
  logic [DATA_W-1:0] exRfA, exRfB, memAluResult, wbValue;
  logic [1:0]        fwdSelA, fwdSelB;
  logic [DATA_W-1:0] operandA, operandB;
  logic [REG_W-1:0]  exDest;
  logic              loadUseStall;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) u_fwd_unit (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expSel(input logic [REG_W-1:0] src,
                                        input logic [REG_W-1:0] md, input logic me,
                                        input logic [REG_W-1:0] wd, input logic we);
    if (me && md != 0 && md == src) return 2'b10;  // R2, R4
    if (we && wd != 0 && wd == src) return 2'b01;  // R3
    return 2'b00;                                   // R5
  endfunction

  function automatic logic [DATA_W-1:0] expOp(input logic [1:0] sel, input logic [DATA_W-1:0] rf);
    case (sel)
      2'b10:   return memAluResult;
      2'b01:   return wbValue;
      default: return rf;
    endcase
  endfunction

  initial begin
    {idRs, idRt, exRs, exRt, exRd, memDest, wbDest} = '0;
    {exRegDst, exMemRead, memWrEn, wbWrEn} = '0;
    exRfA = 32'h1111_2222; exRfB = 32'h3333_4444;
    memAluResult = 32'h5555_6666; wbValue = 32'h7777_8888;
    @(negedge clk);
    check("R1 idle selA", fwdSelA, 2'b00);
    check("R1 idle selB", fwdSelB, 2'b00);
    check("R8 idle stall", loadUseStall, 1'b0);

    // Bypass sweep: sources, stage destinations and enables over regs 0..7.
    for (int s = 0; s < 8 * 8 * 8 * 8 * 4; s++) begin
      @(posedge clk);
      exRs    = REG_W'(s[2:0]);
      exRt    = REG_W'(s[5:3]);
      memDest = REG_W'(s[8:6]);
      wbDest  = REG_W'(s[11:9]);
      memWrEn = s[12];
      wbWrEn  = s[13];
      exRfA = 32'hA0A0_0000 | 32'(s);
      exRfB = 32'hB0B0_0000 | 32'(s);
      memAluResult = 32'hC0C0_0000 | 32'(s);
      wbValue = 32'hD0D0_0000 | 32'(s);
      @(negedge clk);
      begin
        logic [1:0] ea, eb;
        ea = expSel(exRs, memDest, memWrEn, wbDest, wbWrEn);
        eb = expSel(exRt, memDest, memWrEn, wbDest, wbWrEn);
        check("R2/R3/R4/R5 selA", fwdSelA, ea);
        check("R2/R3/R4/R5 selB", fwdSelB, eb);
        check("R6 operandA", operandA, expOp(ea, exRfA));
        check("R6 operandB", operandB, expOp(eb, exRfB));
      end
    end

    // Load-use sweep: destination choice and both decode source fields.
    memWrEn = 1'b0; wbWrEn = 1'b0;
    for (int s = 0; s < 8 * 8 * 8 * 8 * 4; s++) begin
      @(posedge clk);
      exRt      = REG_W'(s[2:0]);
      exRd      = REG_W'(s[5:3]);
      idRs      = REG_W'(s[8:6]);
      idRt      = REG_W'(s[11:9]);
      exRegDst  = s[12];
      exMemRead = s[13];
      @(negedge clk);
      begin
        logic [REG_W-1:0] d;
        logic st;
        d  = exRegDst ? exRd : exRt;
        st = exMemRead && d != 0 && (d == idRs || d == idRt);
        check("R7 exDest", exDest, d);
        check("R8 loadUseStall", loadUseStall, st);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #600us;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1-watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule